// File: doc/BRIEF.md
# Condition-Bit Byte-Lane Pack Unit

This execution-unit datapath writes a group of condition bits into one byte lane of a 32-bit register value. A mode input picks the bit source: either seven predicate bits or four arithmetic flags (zero, sign, carry, overflow). A 2-bit lane selector picks the target byte. A 20-bit immediate mask says which items are written.

The immediate is shifted into the chosen lane and used as a clear mask on the source value. Inside that mask, each item whose mask bit is set and whose index lies below the item count of the current mode is ORed back in. All other bits of the source pass through unchanged.

The result is registered. It appears one clock after the input strobe, together with its own valid strobe. The unit holds no other state.

Top module: `p2r_pack_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no input strobe, `out_valid` is 0.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R3: When `in_valid` is low, `out_data` keeps its previous value, whatever the other inputs do.
- R4: The lane offset is `in_lane` times 8: lane 0 covers bits 7:0, lane 1 covers 15:8, lane 2 covers 23:16 and lane 3 covers 31:24.
- R5: With `in_mode`=0 (predicate mode), for each i from 0 to 6 with `in_mask[i]`=1, result bit (i+offset) equals `in_pred[i]`.
- R6: With `in_mode`=1 (flag mode), items 0, 1, 2 and 3 are the zero, sign, carry and overflow flags, and only those four items can be inserted.
- R7: A mask bit at or above the mode's item count clears its target bit to 0 and never inserts. This covers bit 7 in predicate mode, bits 4 to 6 in flag mode, and bits up to 19 in both modes.
- R8: Every result bit outside (`in_mask` << offset) equals the corresponding `in_src` bit.
- R9: The shifted mask is truncated to 32 bits, so mask bits that land above bit 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operation strobe; also the clock enable of the result register |
| in_mode | input | 1 | 0 selects predicates, 1 selects flags |
| in_lane | input | 2 | Target byte lane |
| in_mask | input | 20 | Immediate item mask |
| in_src | input | 32 | Source register value |
| in_pred | input | 7 | Predicate bits 0 to 6 |
| in_flag_z | input | 1 | Zero flag (item 0 in flag mode) |
| in_flag_s | input | 1 | Sign flag (item 1) |
| in_flag_c | input | 1 | Carry flag (item 2) |
| in_flag_v | input | 1 | Overflow flag (item 3) |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | 32 | Merged result |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, 8-bit lanes, a 20-bit mask, 7 predicates and 4 flags. With these values, lane 3 pushes mask bits 8 to 19 past bit 31, which exercises the truncation rule. Masks wider than either item count exercise the clear-without-insert path in both modes. Random masks, lanes and sources, mixed with directed all-ones and all-zero masks and idle cycles with changing inputs, cover insertion, pass-through and hold.

// File: rtl/p2r_pkg.sv
package p2r_pkg;
  typedef enum logic {
    SRC_PRED = 1'b0,
    SRC_FLAG = 1'b1
  } item_src_e;
endpackage

// File: rtl/p2r_item_sel.sv
module p2r_item_sel
  import p2r_pkg::*;
#(
  parameter int PRED_N = 7,
  parameter int FLAG_N = 4,
  localparam int ITEM_W = (PRED_N > FLAG_N) ? PRED_N : FLAG_N
) (
  input  item_src_e         mode,
  input  logic [PRED_N-1:0] pred,
  input  logic [FLAG_N-1:0] flags,
  output logic [ITEM_W-1:0] items,
  output logic [ITEM_W-1:0] item_en
);
  for (genvar i = 0; i < ITEM_W; i++) begin : g_item
    logic p_bit, f_bit;
    if (i < PRED_N) begin : g_p
      assign p_bit = pred[i];
    end else begin : g_np
      assign p_bit = 1'b0;
    end
    if (i < FLAG_N) begin : g_f
      assign f_bit = flags[i];
    end else begin : g_nf
      assign f_bit = 1'b0;
    end
    always_comb begin
      if (mode == SRC_FLAG) begin
        items[i]   = f_bit;
        item_en[i] = (i < FLAG_N);
      end else begin
        items[i]   = p_bit;
        item_en[i] = (i < PRED_N);
      end
    end
  end
endmodule

// File: rtl/p2r_lane_merge.sv
module p2r_lane_merge #(
  parameter int DATA_W = 32,
  parameter int MASK_W = 20,
  parameter int LANE_W = 8,
  parameter int SEL_W  = 2,
  parameter int ITEM_W = 7,
  localparam int OFF_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [MASK_W-1:0] mask,
  input  logic [SEL_W-1:0]  lane,
  input  logic [ITEM_W-1:0] items,
  input  logic [ITEM_W-1:0] item_en,
  output logic [DATA_W-1:0] merged
);
  logic [OFF_W-1:0]  offset;
  logic [DATA_W-1:0] clr_mask;
  logic [ITEM_W-1:0] ins_raw;
  logic [DATA_W-1:0] ins_bits;

  assign offset   = OFF_W'(lane) * OFF_W'(LANE_W);
  assign clr_mask = DATA_W'(mask) << offset;
  assign ins_raw  = mask[ITEM_W-1:0] & item_en & items;
  assign ins_bits = DATA_W'(ins_raw) << offset;
  assign merged   = (src & ~clr_mask) | ins_bits;

  always_comb begin
    a_r8_passthrough: assert (((merged ^ src) & ~clr_mask) == '0);
    a_r7_insert_in_mask: assert ((ins_bits & ~clr_mask) == '0);
  end
endmodule

// File: rtl/p2r_out_reg.sv
module p2r_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic              q_valid,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= en;
      q       <= q_next;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !q_valid);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/p2r_pack_unit.sv
module p2r_pack_unit
  import p2r_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MASK_W = 20,
  parameter int LANE_W = 8,
  parameter int SEL_W  = 2,
  parameter int PRED_N = 7,
  parameter int FLAG_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [SEL_W-1:0]  in_lane,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [DATA_W-1:0] in_src,
  input  logic [PRED_N-1:0] in_pred,
  input  logic              in_flag_z,
  input  logic              in_flag_s,
  input  logic              in_flag_c,
  input  logic              in_flag_v,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int ITEM_W = (PRED_N > FLAG_N) ? PRED_N : FLAG_N;

  item_src_e         mode;
  logic [FLAG_N-1:0] flags;
  logic [ITEM_W-1:0] items, item_en;
  logic [DATA_W-1:0] merged;

  assign mode  = item_src_e'(in_mode);
  assign flags = FLAG_N'({in_flag_v, in_flag_c, in_flag_s, in_flag_z});

  p2r_item_sel #(.PRED_N(PRED_N), .FLAG_N(FLAG_N)) u_sel (
    .mode(mode), .pred(in_pred), .flags(flags),
    .items(items), .item_en(item_en)
  );

  p2r_lane_merge #(
    .DATA_W(DATA_W), .MASK_W(MASK_W), .LANE_W(LANE_W),
    .SEL_W(SEL_W), .ITEM_W(ITEM_W)
  ) u_merge (
    .src(in_src), .mask(in_mask), .lane(in_lane),
    .items(items), .item_en(item_en), .merged(merged)
  );

  p2r_out_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .d(merged),
    .q_valid(out_valid), .q(out_data)
  );
endmodule

// File: tb/sim_p2r_pack_unit.sv
module sim_p2r_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_mode;
  logic [1:0]  in_lane;
  logic [19:0] in_mask;
  logic [31:0] in_src;
  logic [6:0]  in_pred;
  logic        fz, fs, fc, fv;
  logic        out_valid;
  logic [31:0] out_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  p2r_pack_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_lane(in_lane), .in_mask(in_mask), .in_src(in_src), .in_pred(in_pred),
    .in_flag_z(fz), .in_flag_s(fs), .in_flag_c(fc), .in_flag_v(fv),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] model(logic m, logic [1:0] ln, logic [19:0] mk,
                                        logic [31:0] s, logic [6:0] p,
                                        logic [3:0] f);
    logic [31:0] r;
    int off, cnt;
    off = int'(ln) * 8;
    cnt = m ? 4 : 7;
    r = s;
    for (int k = 0; k < 20; k++)
      if (mk[k] && (k + off) < 32) r[k + off] = 1'b0;
    for (int k = 0; k < cnt; k++)
      if (mk[k] && (m ? f[k] : p[k])) r[k + off] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(string req, logic m, logic [1:0] ln, logic [19:0] mk,
                    logic [31:0] s, logic [6:0] p, logic [3:0] f);
    logic [31:0] e;
    e = model(m, ln, mk, s, p, f);
    in_valid = 1; in_mode = m; in_lane = ln; in_mask = mk; in_src = s;
    in_pred = p; {fv, fc, fs, fz} = f;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    check({req, " R2 valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, e);
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1d5a));
    rst_n = 0; in_valid = 0; in_mode = 0; in_lane = 0; in_mask = 0;
    in_src = 0; in_pred = 0; {fz, fs, fc, fv} = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {31'd0, out_valid}, 32'd0);
    // R5 predicate mode, all items, every lane (R4)
    for (int l = 0; l < 4; l++)
      op("R4 R5 pred lane", 1'b0, 2'(l), 20'h0007F, 32'hA5A5_A5A5, 7'b1010011, 4'h0);
    // R6 flag mode, individual flags
    for (int k = 0; k < 4; k++)
      op("R6 flag item", 1'b1, 2'd1, 20'h0000F, 32'h0, 7'h7F, 4'(1 << k));
    // R7 mask bits above item count clear only
    op("R7 pred bit7", 1'b0, 2'd0, 20'h00080, 32'hFFFF_FFFF, 7'h7F, 4'hF);
    op("R7 flag bits4-6", 1'b1, 2'd2, 20'h00070, 32'hFFFF_FFFF, 7'h7F, 4'hF);
    op("R7 high mask", 1'b0, 2'd0, 20'hFFF00, 32'hFFFF_FFFF, 7'h7F, 4'hF);
    // R9 lane 3 truncates
    op("R9 lane3 full mask", 1'b1, 2'd3, 20'hFFFFF, 32'hFFFF_FFFF, 7'h00, 4'hA);
    // R8 zero mask passes all
    op("R8 zero mask", 1'b0, 2'd2, 20'h0, 32'h1234_5678, 7'h7F, 4'hF);
    // R3 hold while idle with changing inputs
    held = out_data;
    for (int k = 0; k < 4; k++) begin
      in_src = $urandom; in_mask = 20'($urandom); in_lane = 2'($urandom);
      @(posedge clk); @(negedge clk);
      check("R3 hold", out_data, held);
      check("R2 idle", {31'd0, out_valid}, 32'd0);
    end
    // random mix
    for (int k = 0; k < 400; k++)
      op("R5 R6 R8 random", 1'($urandom), 2'($urandom), 20'($urandom),
         $urandom, 7'($urandom), 4'($urandom));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule